// File: doc/BRIEF.md
# Loadable Binary/BCD Up/Down Digit Counter

This block is one four-bit counting stage. It runs in one of two radices, chosen at run time: plain binary, which uses all sixteen codes, or BCD decade, which uses the codes 0 through 9. A direction input makes it count up or down. Counting happens on rising clock edges, and only while an active-low enable (the carry input) is low.

A load-enable input copies a four-bit parallel value into the stage at once, with no clock edge needed. A load takes priority over counting.

The stage drives an active-low terminal flag, the carry output. The flag depends on the radix and the direction. Stages that share one clock can be chained by wiring each stage's carry output to the next stage's carry input. The chain then counts as one synchronous multi-digit counter, in binary or in decimal.

Top module: `updn_digit`

## Requirements
- R1: While `rst` is 1 and `preset_en` is 0, a rising clock edge sets `count` to 0.
- R2: With `bin_mode` = 1, `count_up` = 1, `carry_in_n` = 0 and `preset_en` = 0, each rising edge adds one to `count` modulo 16, so 15 wraps to 0.
- R3: With `bin_mode` = 1, `count_up` = 0 and counting enabled, each rising edge subtracts one modulo 16, so 0 wraps to 15.
- R4: With `bin_mode` = 0 and `count_up` = 1, counting goes 0,1,…,9 and then wraps back to 0.
- R5: With `bin_mode` = 0 and `count_up` = 0, counting goes 9,8,…,0 and then wraps back to 9.
- R6: In decade mode, a count of 10 to 15 (reachable only by loading) moves to 0 on the next enabled edge when counting up, and to 9 when counting down. It never asserts the carry output.
- R7: While `preset_en` = 1, `count` equals `jam` with no clock edge needed.
- R8: Clock edges that arrive while `preset_en` = 1 do not count. After `preset_en` returns to 0, the loaded value stays until the next enabled rising edge.
- R9: While `carry_in_n` = 1, rising edges leave `count` unchanged.
- R10: `carry_out_n` is 0 exactly when `carry_in_n` = 0 and either `count_up` = 1 with `count` at the top value (15 in binary, 9 in decade), or `count_up` = 0 with `count` = 0. Otherwise it is 1.
- R11: While `carry_in_n` = 1, `carry_out_n` is 1 whatever the count.
- R12: Two stages chained through the carry signals, with a shared clock, count as one two-digit counter: modulo 256 in binary, modulo 100 in decade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst | input | 1 | Synchronous reset to zero, active high |
| preset_en | input | 1 | Asynchronous parallel load, active high |
| jam | input | 4 | Parallel load value |
| bin_mode | input | 1 | 1 = binary radix, 0 = BCD decade radix |
| count_up | input | 1 | 1 = count up, 0 = count down |
| carry_in_n | input | 1 | Active-low count enable from the previous stage |
| count | output | 4 | Current count |
| carry_out_n | output | 1 | Active-low terminal flag to the next stage |

## Verification
The hardest state to reach from the ports is a decade stage that holds an illegal code from 10 to 15, because counting never produces one. The bench reaches it only through a load while decade mode is selected. It then releases the load and counts both up and down, checking that the stage goes back to 0 or 9 and that the upper chained digit does not move. A second hard case is a load that is visible before any edge and that straddles an edge. The bench raises the load between edges, samples at once, keeps it raised across an edge with counting enabled, and samples again after releasing it.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
package updn_pkg;

    typedef enum logic {
        RADIX_DEC = 1'b0,
        RADIX_BIN = 1'b1
    } radix_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef struct packed {
        radix_e radix;
        dir_e   dir;
        logic   adv;
        logic   gate;
    } ctrl_t;

    function automatic int unsigned radix_top(radix_e r, int unsigned bin_top,
                                              int unsigned dec_top);
        return (r == RADIX_BIN) ? bin_top : dec_top;
    endfunction

endpackage

// File: rtl/updn_ctrl.sv
`timescale 1ns/1ps
module updn_ctrl
    import updn_pkg::*;
(
    input  logic  bin_mode,
    input  logic  count_up,
    input  logic  carry_in_n,
    input  logic  preset_en,
    output ctrl_t ctrl
);
    always_comb begin
        ctrl.radix = radix_e'(bin_mode);
        ctrl.dir   = dir_e'(count_up);
        ctrl.gate  = ~carry_in_n;
        ctrl.adv   = ~carry_in_n & ~preset_en;
    end
endmodule

// File: rtl/updn_next.sv
`timescale 1ns/1ps
module updn_next
    import updn_pkg::*;
#(
    parameter int W       = 4,
    parameter int DEC_TOP = 9
) (
    input  ctrl_t          ctrl,
    input  logic [W-1:0]   cur,
    output logic [W-1:0]   nxt,
    output logic [W-1:0]   top
);
    localparam int unsigned BIN_TOP = (1 << W) - 1;

    always_comb begin
        top = W'(radix_top(ctrl.radix, BIN_TOP, DEC_TOP));
        if (ctrl.dir == DIR_UP) begin
            nxt = (cur >= top) ? '0 : cur + 1'b1;
        end else begin
            nxt = ((cur == '0) || (cur > top)) ? top : cur - 1'b1;
        end
    end
endmodule

// File: rtl/updn_term.sv
`timescale 1ns/1ps
module updn_term
    import updn_pkg::*;
#(
    parameter int W = 4
) (
    input  ctrl_t        ctrl,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] top,
    output logic         carry_out_n
);
    logic at_end;

    always_comb begin
        at_end      = (ctrl.dir == DIR_UP) ? (cur == top) : (cur == '0);
        carry_out_n = ~(ctrl.gate & at_end);
    end
endmodule

// File: rtl/updn_store.sv
`timescale 1ns/1ps
module updn_store #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] jam,
    input  logic         adv,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] q
);
    logic [W-1:0] held;

    always_ff @(posedge clk or posedge load) begin
        if (load) begin
            held <= jam;
        end else if (rst) begin
            held <= '0;
        end else if (adv) begin
            held <= nxt;
        end
    end

    // transparent while loading, so the load value tracks jam at once
    assign q = load ? jam : held;
endmodule

// File: rtl/updn_digit.sv
`timescale 1ns/1ps
module updn_digit
    import updn_pkg::*;
#(
    parameter int W       = 4,
    parameter int DEC_TOP = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         preset_en,
    input  logic [W-1:0] jam,
    input  logic         bin_mode,
    input  logic         count_up,
    input  logic         carry_in_n,
    output logic [W-1:0] count,
    output logic         carry_out_n
);
    ctrl_t        ctrl;
    logic [W-1:0] nxt;
    logic [W-1:0] top;
    logic [W-1:0] q;

    updn_ctrl u_ctrl (
        .bin_mode   (bin_mode),
        .count_up   (count_up),
        .carry_in_n (carry_in_n),
        .preset_en  (preset_en),
        .ctrl       (ctrl)
    );

    updn_next #(.W(W), .DEC_TOP(DEC_TOP)) u_next (
        .ctrl (ctrl),
        .cur  (q),
        .nxt  (nxt),
        .top  (top)
    );

    updn_store #(.W(W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .load (preset_en),
        .jam  (jam),
        .adv  (ctrl.adv),
        .nxt  (nxt),
        .q    (q)
    );

    updn_term #(.W(W)) u_term (
        .ctrl        (ctrl),
        .cur         (q),
        .top         (top),
        .carry_out_n (carry_out_n)
    );

    assign count = q;
endmodule

// File: rtl/updn_digit_chk.sv
`timescale 1ns/1ps
module updn_digit_chk #(
    parameter int W       = 4,
    parameter int DEC_TOP = 9
) (
    input logic         clk,
    input logic         rst,
    input logic         preset_en,
    input logic [W-1:0] jam,
    input logic         bin_mode,
    input logic         count_up,
    input logic         carry_in_n,
    input logic [W-1:0] count,
    input logic         carry_out_n
);
    assert_jam_visible_R7: assert property (@(posedge clk) disable iff (rst)
        preset_en |-> (count == jam));

    assert_carry_idle_R11: assert property (@(posedge clk) disable iff (rst)
        carry_in_n |-> carry_out_n);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(carry_in_n) && !$past(preset_en) && !preset_en)
        |-> (count == $past(count)));

    assert_dec_legal_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(preset_en) && !$past(carry_in_n) && !$past(bin_mode)
         && !preset_en) |-> (count <= W'(DEC_TOP)));

    assert_bin_up_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(preset_en) && !$past(carry_in_n) && $past(bin_mode)
         && $past(count_up) && !preset_en) |-> (count == W'($past(count) + 1'b1)));

    assert_bin_down_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(preset_en) && !$past(carry_in_n) && $past(bin_mode)
         && !$past(count_up) && !preset_en) |-> (count == W'($past(count) - 1'b1)));

    assert_term_down_R10: assert property (@(posedge clk) disable iff (rst)
        (!carry_in_n && !count_up && (count == '0)) |-> !carry_out_n);
endmodule

bind updn_digit updn_digit_chk #(.W(W), .DEC_TOP(DEC_TOP)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .preset_en   (preset_en),
    .jam         (jam),
    .bin_mode    (bin_mode),
    .count_up    (count_up),
    .carry_in_n  (carry_in_n),
    .count       (count),
    .carry_out_n (carry_out_n)
);

// File: tb/updn_digit_test.sv
`timescale 1ns/1ps
module updn_digit_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst, preset_en, bin_mode, count_up, lo_cin_n;
    logic [3:0] jam_lo, jam_hi, lo_q, hi_q;
    logic       lo_co_n, hi_co_n;

    updn_digit uut (
        .clk(clk), .rst(rst), .preset_en(preset_en), .jam(jam_lo),
        .bin_mode(bin_mode), .count_up(count_up), .carry_in_n(lo_cin_n),
        .count(lo_q), .carry_out_n(lo_co_n)
    );

    updn_digit uut_hi (
        .clk(clk), .rst(rst), .preset_en(preset_en), .jam(jam_hi),
        .bin_mode(bin_mode), .count_up(count_up), .carry_in_n(lo_co_n),
        .count(hi_q), .carry_out_n(hi_co_n)
    );

    int tests = 0;
    int fails = 0;
    int total = 0;
    bit done  = 0;

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int radix();
        return bin_mode ? 16 : 10;
    endfunction

    task automatic check_state(string tag);
        int m  = radix();
        int lo = total % m;
        int co = (!lo_cin_n && ((count_up && lo == m - 1) || (!count_up && lo == 0))) ? 0 : 1;
        check({tag, " low digit"}, int'(lo_q), lo);
        check({tag, " high digit"}, int'(hi_q), total / m);
        check({tag, " R10 carry"}, int'(lo_co_n), co);
    endtask

    task automatic steps(int n, string tag);
        for (int i = 0; i < n; i++) begin
            int m = radix();
            @(posedge clk); #2;
            if (!lo_cin_n)
                total = count_up ? (total + 1) % (m * m) : (total + m * m - 1) % (m * m);
            check_state(tag);
        end
    endtask

    task automatic load(int lo, int hi);
        jam_lo = 4'(lo); jam_hi = 4'(hi);
        preset_en = 1'b1;
        #1;
        check("R7 load visible low", int'(lo_q), lo);
        check("R7 load visible high", int'(hi_q), hi);
        @(posedge clk); #2;
        check("R8 held across edge", int'(lo_q), lo);
        preset_en = 1'b0;
        #1;
        check("R8 kept after release", int'(lo_q), lo);
        check("R8 kept after release high", int'(hi_q), hi);
        total = hi * radix() + lo;
    endtask

    initial begin
        rst = 1'b1; preset_en = 1'b0; jam_lo = '0; jam_hi = '0;
        bin_mode = 1'b1; count_up = 1'b1; lo_cin_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset low", int'(lo_q), 0);
        check("R1 reset high", int'(hi_q), 0);
        check("R11 idle carry", int'(lo_co_n), 1);
        rst = 1'b0;

        // binary sweeps through the two-digit chain
        lo_cin_n = 1'b0; total = 0;
        steps(300, "R2 R12");
        count_up = 1'b0;
        steps(300, "R3 R12");

        // decade sweeps
        bin_mode = 1'b0;
        load(0, 0);
        count_up = 1'b1;
        steps(120, "R4 R12");
        count_up = 1'b0;
        steps(120, "R5 R12");

        // illegal decade codes reached by loading
        for (int v = 10; v < 16; v++) begin
            for (int d = 0; d < 2; d++) begin
                count_up = d[0];
                load(v, 3);
                check("R6 no carry on illegal code", int'(lo_co_n), 1);
                @(posedge clk); #2;
                check("R6 recovery", int'(lo_q), d ? 0 : 9);
                check("R6 upper digit still", int'(hi_q), 3);
            end
        end

        // carry-in hold
        bin_mode = 1'b1; count_up = 1'b1;
        load(5, 7);
        lo_cin_n = 1'b1;
        steps(4, "R9");
        load(15, 2);
        steps(3, "R9 R11");
        lo_cin_n = 1'b0;
        #1;
        check("R10 carry at top", int'(lo_co_n), 0);
        steps(1, "R10 R12");

        // reset in the middle of counting
        rst = 1'b1;
        @(posedge clk); #2;
        check("R1 reset mid-count low", int'(lo_q), 0);
        check("R1 reset mid-count high", int'(hi_q), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule